// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block chooses which interrupt a small 8-bit CPU core services next. Six request sources feed it. Two are external request flags, timers 0 and 1 each give one overflow flag, the serial port gives a receive flag and a transmit flag, and timer 2 gives two flags. The serial and timer 2 sources are each the OR of their two flags. Two registers control the choice. The enable register holds one bit per source plus a global bit. The priority register marks each source as high or low level.

The CPU samples a request only on the last cycle of an instruction. The block blocks that sample when the instruction is a return from interrupt or a write to the enable or priority register, so one more instruction always runs before the next vector is taken. An accepted request is held on the vector outputs until the CPU acknowledges it. The acknowledge marks the level as in service and pulses clear strobes for the flags that hardware may clear.

A return releases the highest level that is active. Because the block tracks in-service state per level, a high request can preempt a low routine. Nothing preempts a high routine, and no routine is preempted by a request of its own level.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the enable and priority registers read 00H, no vector is presented, `vec_addr_o` is 0000H, `vec_src_o` is 0 and both in-service bits are 0.
- R2: A source raises a request only when its own enable bit and the global enable bit (enable register bit 7) are both 1. The enable bits are: bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial, bit 5 timer 2.
- R3: A write with `reg_sel_i`=0 loads the enable register and a write with `reg_sel_i`=1 loads the priority register. Enable bit 6 and priority bits 7:6 always read 0. The priority bits use the same source order as the enable bits.
- R4: Among requests of the same level, the winner follows the order external 0, timer 0, external 1, timer 1, serial, timer 2. The source index runs 0 to 5 in that order.
- R5: A priority bit of 1 makes its source high level. When requests of both levels are pending, a high-level request wins over any low-level one.
- R6: A presented vector has address 0003H + 8 × source index (0003H, 000BH, 0013H, 001BH, 0023H, 002BH), and `vec_src_o` gives the source index.
- R7: A request is accepted only in a cycle with `instr_last_i`=1, and `vec_valid_o` rises on the next cycle. While `vec_ack_i` is low, the vector holds its address and source. One cycle after `vec_ack_i` the valid output drops.
- R8: During the acknowledge cycle, `flag_clr_o` pulses only the bit of the accepted flag, and only for external 0, timer 0, external 1 and timer 1 (flag bits 0 to 3). Flag bits 4 to 7 are never cleared by hardware.
- R9: The acknowledge sets the in-service bit of the accepted level (`in_service_o` bit 0 low, bit 1 high). While a low routine is in service, only high requests are accepted. While a high routine is in service, no request is accepted.
- R10: A return (`reti_i`) clears the high in-service bit if it is set, and otherwise clears the low one.
- R11: A sample cycle that also carries `reti_i` or `reg_wr_i` accepts nothing. The next sample cycle without them accepts normally.
- R12: The serial source requests when either of flag bits 4 (receive) or 5 (transmit) is set. The timer 2 source requests when either of flag bits 6 or 7 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flag_i | input | 8 | Flags: ext0, tmr0, ext1, tmr1, rx, tx, tmr2 overflow, tmr2 external |
| instr_last_i | input | 1 | Current cycle is the last cycle of an instruction |
| reti_i | input | 1 | Instruction in progress is a return from interrupt |
| reg_wr_i | input | 1 | Write to the enable or priority register |
| reg_sel_i | input | 1 | 0 selects the enable register, 1 selects the priority register |
| reg_wdata_i | input | 8 | Register write data |
| en_o | output | 8 | Enable register value |
| prio_o | output | 8 | Priority register value |
| vec_valid_o | output | 1 | Vector presented |
| vec_addr_o | output | 16 | Vector address |
| vec_src_o | output | 3 | Accepted source index |
| vec_ack_i | input | 1 | CPU takes the vector |
| flag_clr_o | output | 8 | Hardware clear strobes per flag |
| in_service_o | output | 2 | In-service bits: bit 0 low, bit 1 high |

## Verification
Every cycle, the assertions check three things. A vector appears only after an unblocked sample cycle, and never while a high routine is in service. A presented vector stays stable until it is acknowledged and is aligned to its 8-byte slot. Clear strobes fire only under an acknowledge, and a return lowers the in-service count. The bench scenarios are the only place to show the rest: the enable gating, the tie-break order, the precedence of high over low, the OR of the two-flag sources, and the nesting sequence through two levels with the returns that unwind it.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC      = 6;
  localparam int SRC_W     = $clog2(NSRC);
  localparam int FLAG_W    = 8;
  localparam int REG_W     = 8;
  localparam int GLOBAL_EN = 7;
  localparam int HW_CLR_N  = 4;               // sources 0..3 cleared by hardware
  localparam logic [REG_W-1:0] EN_MASK = 8'hBF;
  localparam logic [REG_W-1:0] PR_MASK = 8'h3F;
  localparam logic [15:0] VEC_BASE  = 16'h0003;
  localparam int          VEC_SHIFT = 3;

  function automatic logic [15:0] vec_of(input logic [SRC_W-1:0] s);
    return VEC_BASE + (16'(s) << VEC_SHIFT);
  endfunction
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             sel_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] en_o,
  output logic [REG_W-1:0] prio_o
);
  logic [REG_W-1:0] en_q, pr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
      pr_q <= '0;
    end else if (wr_i) begin
      if (sel_i) pr_q <= wdata_i & PR_MASK;
      else       en_q <= wdata_i & EN_MASK;
    end
  end

  assign en_o   = en_q;
  assign prio_o = pr_q;

  AST_UNUSED_BITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (en_q[6] == 1'b0) && (pr_q[7:6] == 2'b00)); // R3
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int N   = NSRC,
  parameter int IDX = SRC_W
) (
  input  logic [N-1:0]   req_i,
  input  logic [N-1:0]   prio_i,
  input  logic           allow_hi_i,
  input  logic           allow_lo_i,
  output logic           win_valid_o,
  output logic [IDX-1:0] win_idx_o,
  output logic           win_hi_o
);
  logic [N-1:0]   hi_req, lo_req;
  logic           hi_any, lo_any;
  logic [IDX-1:0] hi_idx, lo_idx;

  assign hi_req = allow_hi_i ? (req_i & prio_i)  : '0;
  assign lo_req = allow_lo_i ? (req_i & ~prio_i) : '0;

  // lowest index wins within a level
  always_comb begin
    hi_any = 1'b0;
    lo_any = 1'b0;
    hi_idx = '0;
    lo_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hi_req[i]) begin hi_any = 1'b1; hi_idx = IDX'(i); end
      if (lo_req[i]) begin lo_any = 1'b1; lo_idx = IDX'(i); end
    end
  end

  assign win_valid_o = hi_any | lo_any;
  assign win_hi_o    = hi_any;
  assign win_idx_o   = hi_any ? hi_idx : lo_idx;
endmodule

// File: rtl/irq_level_track.sv
module irq_level_track (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       set_i,
  input  logic       set_hi_i,
  input  logic       release_i,
  output logic [1:0] isr_o,
  output logic       allow_hi_o,
  output logic       allow_lo_o
);
  logic [1:0] isr_q, isr_d;

  always_comb begin
    isr_d = isr_q;
    if (release_i) begin
      if (isr_q[1]) isr_d[1] = 1'b0;
      else          isr_d[0] = 1'b0;
    end
    if (set_i) isr_d[set_hi_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_q <= '0;
    else         isr_q <= isr_d;
  end

  assign isr_o      = isr_q;
  assign allow_hi_o = ~isr_q[1];
  assign allow_lo_o = (isr_q == 2'b00);

  AST_RETI_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (release_i && !set_i && (isr_q != 2'b00)) |=>
      ($countones(isr_q) < $past($countones(isr_q)))); // R10
  AST_SET_MARKS_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !release_i) |=> isr_q[$past(set_hi_i)]); // R9
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FLAG_W-1:0] flag_i,
  input  logic              instr_last_i,
  input  logic              reti_i,
  input  logic              reg_wr_i,
  input  logic              reg_sel_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  en_o,
  output logic [REG_W-1:0]  prio_o,
  output logic              vec_valid_o,
  output logic [15:0]       vec_addr_o,
  output logic [SRC_W-1:0]  vec_src_o,
  input  logic              vec_ack_i,
  output logic [FLAG_W-1:0] flag_clr_o,
  output logic [1:0]        in_service_o
);
  logic [REG_W-1:0] en_q, pr_q;
  logic [NSRC-1:0]  src_flag, src_req;
  logic             allow_hi, allow_lo;
  logic             win_valid, win_hi;
  logic [SRC_W-1:0] win_idx;
  logic             pend_q, lvl_q;
  logic [SRC_W-1:0] src_q;
  logic             poll_ok, accept, ack_ok;
  logic [1:0]       isr;

  irq_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .sel_i   (reg_sel_i),
    .wdata_i (reg_wdata_i),
    .en_o    (en_q),
    .prio_o  (pr_q)
  );

  // single-flag sources map straight, dual-flag sources are ORed
  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_src
      if (g < HW_CLR_N) begin : g_single
        assign src_flag[g] = flag_i[g];
      end else begin : g_dual
        assign src_flag[g] = flag_i[2*g - HW_CLR_N] | flag_i[2*g - HW_CLR_N + 1];
      end
    end
  endgenerate

  assign src_req = en_q[GLOBAL_EN] ? (src_flag & en_q[NSRC-1:0]) : '0;

  irq_arbiter #(.N(NSRC), .IDX(SRC_W)) u_arb (
    .req_i       (src_req),
    .prio_i      (pr_q[NSRC-1:0]),
    .allow_hi_i  (allow_hi),
    .allow_lo_i  (allow_lo),
    .win_valid_o (win_valid),
    .win_idx_o   (win_idx),
    .win_hi_o    (win_hi)
  );

  assign poll_ok = instr_last_i & ~reti_i & ~reg_wr_i & ~pend_q;
  assign accept  = poll_ok & win_valid;
  assign ack_ok  = vec_ack_i & pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      src_q  <= '0;
      lvl_q  <= 1'b0;
    end else if (accept) begin
      pend_q <= 1'b1;
      src_q  <= win_idx;
      lvl_q  <= win_hi;
    end else if (ack_ok) begin
      pend_q <= 1'b0;
    end
  end

  irq_level_track u_lvl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (ack_ok),
    .set_hi_i   (lvl_q),
    .release_i  (reti_i),
    .isr_o      (isr),
    .allow_hi_o (allow_hi),
    .allow_lo_o (allow_lo)
  );

  always_comb begin
    flag_clr_o = '0;
    if (ack_ok && (int'(src_q) < HW_CLR_N)) flag_clr_o[src_q] = 1'b1;
  end

  assign en_o         = en_q;
  assign prio_o       = pr_q;
  assign vec_valid_o  = pend_q;
  assign vec_src_o    = pend_q ? src_q : '0;
  assign vec_addr_o   = pend_q ? vec_of(src_q) : 16'h0000;
  assign in_service_o = isr;

  AST_ACCEPT_ON_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vec_valid_o) |-> $past(instr_last_i)); // R7
  AST_BLOCK_RETI_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vec_valid_o) |-> $past(!reti_i && !reg_wr_i)); // R11
  AST_VEC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_valid_o && !vec_ack_i) |=> (vec_valid_o && $stable(vec_addr_o) && $stable(vec_src_o))); // R7
  AST_ACK_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_valid_o && vec_ack_i) |=> !vec_valid_o); // R7
  AST_HI_NOT_PREEMPTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vec_valid_o) |-> !$past(in_service_o[1])); // R9
  AST_VEC_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> (vec_addr_o[2:0] == 3'b011) && (vec_addr_o[15:6] == '0)); // R6
  AST_CLR_NEEDS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|flag_clr_o) |-> (vec_ack_i && vec_valid_o && $onehot(flag_clr_o))); // R8
endmodule

// File: tb/irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  flag = '0;
  logic        ilast = 1'b0, reti = 1'b0, wr = 1'b0, sel = 1'b0, ack = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  en, prio, clr;
  logic        vvalid;
  logic [15:0] vaddr;
  logic [2:0]  vsrc;
  logic [1:0]  isr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .flag_i(flag), .instr_last_i(ilast),
    .reti_i(reti), .reg_wr_i(wr), .reg_sel_i(sel), .reg_wdata_i(wdata),
    .en_o(en), .prio_o(prio), .vec_valid_o(vvalid), .vec_addr_o(vaddr),
    .vec_src_o(vsrc), .vec_ack_i(ack), .flag_clr_o(clr), .in_service_o(isr)
  );

  // {en, prio, flags, exp_valid, exp_src}
  localparam int NROW = 10;
  localparam logic [27:0] TBL [NROW] = '{
    {8'h81, 8'h00, 8'h01, 1'b1, 3'd0},   // R2 ext0 fully enabled
    {8'h01, 8'h00, 8'h01, 1'b0, 3'd0},   // R2 no global enable
    {8'hBF, 8'h00, 8'h0F, 1'b1, 3'd0},   // R4 ext0 first
    {8'hBF, 8'h00, 8'h0A, 1'b1, 3'd1},   // R4 timer0 over timer1
    {8'hBF, 8'h08, 8'h0B, 1'b1, 3'd3},   // R5 high timer1 wins
    {8'h90, 8'h00, 8'h20, 1'b1, 3'd4},   // R12 tx flag alone
    {8'hA0, 8'h00, 8'h80, 1'b1, 3'd5},   // R12 timer2 external flag
    {8'h9F, 8'h00, 8'hC0, 1'b0, 3'd0},   // R2 timer2 disabled
    {8'hBF, 8'h20, 8'h41, 1'b1, 3'd5},   // R5 high timer2 over low ext0
    {8'h88, 8'h00, 8'h04, 1'b0, 3'd0}    // R2 ext1 not enabled
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; flag = '0; ilast = 0; reti = 0; wr = 0; ack = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wreg(input logic s, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic poll(input logic with_reti, input logic with_wr);
    @(negedge clk);
    ilast = 1'b1; reti = with_reti; wr = with_wr; sel = 1'b0; wdata = en;
    @(negedge clk);
    ilast = 1'b0; reti = 1'b0; wr = 1'b0;
  endtask

  task automatic do_ack(input logic [7:0] exp_clr, input string rq);
    @(negedge clk);
    ack = 1'b1;
    #1;
    chk(rq, clr, exp_clr);
    @(negedge clk);
    ack = 1'b0;
    chk("R7 valid drops after ack", vvalid, 0);
  endtask

  task automatic do_reti();
    @(negedge clk);
    reti = 1'b1;
    @(negedge clk);
    reti = 1'b0;
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
      end
    end
  end

  initial begin
    logic [7:0] exp_clr;
    do_reset();
    // R1 reset state
    chk("R1 en", en, 8'h00);
    chk("R1 prio", prio, 8'h00);
    chk("R1 valid", vvalid, 0);
    chk("R1 addr", vaddr, 16'h0000);
    chk("R1 src", vsrc, 0);
    chk("R1 in_service", isr, 0);

    // table walk
    for (int r = 0; r < NROW; r++) begin
      do_reset();
      wreg(1'b0, TBL[r][27:20]);
      wreg(1'b1, TBL[r][19:12]);
      @(negedge clk);
      flag = TBL[r][11:4];
      poll(1'b0, 1'b0);
      chk($sformatf("R4/R5 row %0d valid", r), vvalid, TBL[r][3]);
      if (TBL[r][3]) begin
        chk($sformatf("R4/R5 row %0d src", r), vsrc, TBL[r][2:0]);
        chk($sformatf("R6 row %0d addr", r), vaddr, 16'h0003 + 16'(TBL[r][2:0]) * 16'd8);
        exp_clr = (TBL[r][2:0] < 3'd4) ? (8'h01 << TBL[r][2:0]) : 8'h00;
        do_ack(exp_clr, $sformatf("R8 row %0d clear", r));
        chk($sformatf("R9 row %0d level", r), isr,
            TBL[r][12 + TBL[r][2:0]] ? 2'b10 : 2'b01);
      end
    end

    // R3 masked register bits
    do_reset();
    wreg(1'b0, 8'hFF);
    wreg(1'b1, 8'hFF);
    chk("R3 en readback", en, 8'hBF);
    chk("R3 prio readback", prio, 8'h3F);

    // R7 no acceptance without last cycle; vector held until ack
    do_reset();
    wreg(1'b0, 8'h82);
    @(negedge clk);
    flag = 8'h02;
    repeat (3) @(negedge clk);
    chk("R7 no accept without instr_last", vvalid, 0);
    poll(1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk("R7 vector held", vvalid, 1);
    chk("R7 addr held", vaddr, 16'h000B);
    do_ack(8'h02, "R8 timer0 cleared");

    // R11 return and register write block one sample
    do_reset();
    wreg(1'b0, 8'hBF);
    @(negedge clk);
    flag = 8'h01;
    poll(1'b1, 1'b0);
    chk("R11 reti blocks", vvalid, 0);
    poll(1'b0, 1'b1);
    chk("R11 write blocks", vvalid, 0);
    poll(1'b0, 1'b0);
    chk("R11 next sample accepts", vvalid, 1);

    // R9/R10 nesting
    do_reset();
    wreg(1'b0, 8'hBF);
    @(negedge clk);
    flag = 8'h01;
    poll(1'b0, 1'b0);
    do_ack(8'h01, "R8 ext0 cleared");
    chk("R9 low in service", isr, 2'b01);
    @(negedge clk);
    flag = 8'h02;
    poll(1'b0, 1'b0);
    chk("R9 same level not accepted", vvalid, 0);
    wreg(1'b1, 8'h08);
    @(negedge clk);
    flag = 8'h0A;
    poll(1'b0, 1'b0);
    chk("R9 high preempts low", vvalid, 1);
    chk("R9 preempting source", vsrc, 3'd3);
    do_ack(8'h08, "R8 timer1 cleared");
    chk("R9 both levels", isr, 2'b11);
    wreg(1'b1, 8'h0A);
    poll(1'b0, 1'b0);
    chk("R9 high not preempted", vvalid, 0);
    do_reti();
    chk("R10 high released first", isr, 2'b01);
    do_reti();
    chk("R10 low released", isr, 2'b00);
    poll(1'b0, 1'b0);
    chk("R10 pending accepted after unwind", vvalid, 1);
    chk("R5 high timer0 chosen", vsrc, 3'd1);

    finish_run();
  end
endmodule